// File: doc/BRIEF.md
# First-Word Fall-Through Output Stage

This block is the read side of a synchronous queue. It holds the word storage, the write and read pointers, the output data register and the registers behind the two status pins. Its behaviour is chosen once, while master reset is held low, from the `mode_sel` input. Partial reset empties the queue but keeps that choice.

In standard mode a word reaches `rd_data` only on a read request. `rd_flag` works as an empty flag and `wr_flag` works as a full flag. In fall-through mode the oldest stored word is moved to `rd_data` without a request. `rd_flag` then signals that the output is valid, and `wr_flag` signals that the block can take a write. Both fall-through flags are pipelined. A new word needs three clock edges to reach the output, and space freed by a read needs two edges to show on `wr_flag`.

The whole block runs on one clock. The pointer-delay registers set the fall-through latencies as fixed cycle counts.

Top module: `fwft_out_stage`

## Requirements
- R1: While `mrst_n` is low, the mode is taken from `mode_sel` (1 = fall-through, 0 = standard). It keeps that value after `mrst_n` rises, whatever `mode_sel` or `prst_n` do. In standard mode, written words never reach `rd_data` without a read.
- R2: In standard mode, the edge after a master or partial reset leaves `rd_flag` low (empty) and `wr_flag` high (not full).
- R3: In fall-through mode, the edge after a master or partial reset leaves `rd_flag` high (no valid output) and `wr_flag` low (ready for writes).
- R4: In standard mode, `rd_en` high while `rd_flag` is high loads the oldest word into `rd_data` on that edge. `rd_flag` is high after any edge that leaves at least one word stored, and low otherwise.
- R5: In standard mode, `rd_en` while `rd_flag` is low is ignored, and `rd_data` keeps its value.
- R6: A write is accepted only when `wr_flag` shows room: high in standard mode, low in fall-through mode. Any other write is ignored. In standard mode `wr_flag` goes low after the edge that stores the DEPTH-th word.
- R7: In fall-through mode, a word written into an empty block appears on `rd_data`, with `rd_flag` low, after the third rising edge that follows the write edge. `rd_flag` is still high after the first and second of those edges.
- R8: In fall-through mode, `rd_en` while `rd_flag` is low consumes the displayed word. The next stored word is shown on the same edge if one is visible. If the consumed word was the last one, `rd_flag` goes high after that edge. Without `rd_en`, the displayed word and `rd_flag` hold.
- R9: In fall-through mode, `rd_en` while `rd_flag` is high consumes nothing.
- R10: In fall-through mode, the block holds DEPTH+1 words: DEPTH in storage and one in the output register. When the block is full and a word is consumed, `wr_flag` stays high after the consuming edge and the next edge, and goes low after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| mrst_n | input | 1 | Synchronous master reset, active low; samples `mode_sel` |
| prst_n | input | 1 | Synchronous partial reset, active low; empties the queue and keeps the mode |
| mode_sel | input | 1 | Mode choice sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request, active high |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request (standard) or consume request (fall-through), active high |
| rd_data | output | DATA_W | Output data register |
| rd_flag | output | 1 | Standard: high when not empty. Fall-through: low when `rd_data` is valid |
| wr_flag | output | 1 | Standard: low when full. Fall-through: low when a write can be accepted |

## Verification
A pointer or count that slips shows up as a reordered, duplicated or lost word. The scoreboard catches it on the next consumption, or when a drain ends with words left over or with `rd_flag` signalling data too soon. A delay register that is missing or extra shifts the fall-through output or the recovery of `wr_flag` by one edge. The bench samples each of these edge by edge after a single write and after a single read from full, so such an error shows within three cycles. A wrong mode latch or wrong reset values change both flags on the first cycle after reset.

// File: rtl/fwft_out_pkg.sv
// Shared types for the fall-through output stage.
package fwft_out_pkg;
    // Operating behaviour chosen at master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } out_mode_e;
endpackage

// File: rtl/fwft_word_store.sv
// Word storage: one synchronous write port and one combinational read port.
// Assumes DEPTH is a power of two. There is no reset; the pointers decide
// which entries are meaningful.
module fwft_word_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Store the accepted word at the write address.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fwft_ptr_delay.sv
// Delay line for a pointer: STAGES registers cleared together.
// With STAGES = 0 the pointer passes straight through.
module fwft_ptr_delay #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] pipe [STAGES];

            // Shift the pointer one stage per edge; clear all stages on reset.
            always_ff @(posedge clk) begin
                if (clr) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign q = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/fwft_write_ctrl.sv
// Write pointer and the registered "no room" indication. A write is
// accepted only while full_q is clear. In standard mode the room check uses
// the read pointer after this edge, so it is exact. In fall-through mode it
// uses a delayed copy of the read pointer, which can only lag, so the check
// errs on the safe side.
module fwft_write_ctrl
    import fwft_out_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          clr,
    input  out_mode_e     mode,
    input  logic          wr_en,
    input  logic [PW-1:0] rptr_nxt,
    input  logic [PW-1:0] rptr_seen,
    output logic          we,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wptr_nxt,
    output logic          full_q
);
    logic [PW-1:0] rp_ref;

    // Pick the read pointer the room check is based on.
    always_comb begin
        rp_ref   = (mode == MODE_FALL) ? rptr_seen : rptr_nxt;
        we       = wr_en && !full_q;
        wptr_nxt = wptr + PW'(we);
    end

    // Advance the write pointer and register the full indication.
    always_ff @(posedge clk) begin
        if (clr) begin
            wptr   <= '0;
            full_q <= 1'b0;
        end else begin
            wptr   <= wptr_nxt;
            full_q <= ((wptr_nxt - rp_ref) == PW'(DEPTH));
        end
    end
endmodule

// File: rtl/fwft_read_ctrl.sv
// Read pointer, output data register and the "output holds data" bit.
// Standard mode: a request with data present loads the output, and the bit
// tracks "not empty" from the pointers after this edge.
// Fall-through mode: the output register fills itself from words made
// visible by the delayed write pointer, and the bit means "output valid".
module fwft_read_ctrl
    import fwft_out_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              clr,
    input  out_mode_e         mode,
    input  logic              rd_en,
    input  logic [PW-1:0]     wptr_nxt,
    input  logic [PW-1:0]     wptr_seen,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PW-1:0]     rptr,
    output logic [PW-1:0]     rptr_nxt,
    output logic [DATA_W-1:0] rd_data,
    output logic              avail_q
);
    logic take;
    logic avail_nxt;

    // Decide whether a stored word moves to the output on this edge.
    always_comb begin
        if (mode == MODE_FALL) begin
            take      = (wptr_seen != rptr) && (!avail_q || rd_en);
            rptr_nxt  = rptr + PW'(take);
            avail_nxt = take || (avail_q && !rd_en);
        end else begin
            take      = rd_en && avail_q;
            rptr_nxt  = rptr + PW'(take);
            avail_nxt = (wptr_nxt != rptr_nxt);
        end
    end

    // Register the pointer, the output word and the data-present bit.
    always_ff @(posedge clk) begin
        if (clr) begin
            rptr    <= '0;
            rd_data <= '0;
            avail_q <= 1'b0;
        end else begin
            rptr    <= rptr_nxt;
            avail_q <= avail_nxt;
            if (take) begin
                rd_data <= mem_rdata;
            end
        end
    end
endmodule

// File: rtl/fwft_out_stage.sv
// Top of the output stage. It latches the mode during master reset, wires
// the storage, the two control halves and the pointer delays, and maps the
// internal state onto the two status pins according to the mode.
// Assumes one clock, and DEPTH a power of two of at least 2.
module fwft_out_stage
    import fwft_out_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 8,
    parameter int WP_STAGES  = 2,
    parameter int RP_STAGES  = 1
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              mode_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              wr_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    out_mode_e         mode_q;
    logic              clr;
    logic              we;
    logic              full_q;
    logic              avail_q;
    logic [PW-1:0]     wptr, wptr_nxt, wptr_seen;
    logic [PW-1:0]     rptr, rptr_nxt, rptr_seen;
    logic [DATA_W-1:0] mem_rdata;

    assign clr = !mrst_n || !prst_n;

    // Capture the mode choice only while master reset is held.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= out_mode_e'(mode_sel);
        end
    end

    fwft_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (wptr[AW-1:0]),
        .wdata (wr_data),
        .raddr (rptr[AW-1:0]),
        .rdata (mem_rdata)
    );

    fwft_write_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk       (clk),
        .clr       (clr),
        .mode      (mode_q),
        .wr_en     (wr_en),
        .rptr_nxt  (rptr_nxt),
        .rptr_seen (rptr_seen),
        .we        (we),
        .wptr      (wptr),
        .wptr_nxt  (wptr_nxt),
        .full_q    (full_q)
    );

    fwft_read_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .clk       (clk),
        .clr       (clr),
        .mode      (mode_q),
        .rd_en     (rd_en),
        .wptr_nxt  (wptr_nxt),
        .wptr_seen (wptr_seen),
        .mem_rdata (mem_rdata),
        .rptr      (rptr),
        .rptr_nxt  (rptr_nxt),
        .rd_data   (rd_data),
        .avail_q   (avail_q)
    );

    fwft_ptr_delay #(.W(PW), .STAGES(WP_STAGES)) u_wp_dly (
        .clk (clk),
        .clr (clr),
        .d   (wptr),
        .q   (wptr_seen)
    );

    fwft_ptr_delay #(.W(PW), .STAGES(RP_STAGES)) u_rp_dly (
        .clk (clk),
        .clr (clr),
        .d   (rptr),
        .q   (rptr_seen)
    );

    // Map the internal state to the pins; polarity depends on the mode.
    always_comb begin
        rd_flag = (mode_q == MODE_FALL) ? !avail_q : avail_q;
        wr_flag = (mode_q == MODE_FALL) ? full_q   : !full_q;
    end
endmodule

// File: rtl/fwft_out_stage_chk.sv
// Property checker for fwft_out_stage, attached with bind below.
// ft is 1 when the latched mode is fall-through.
module fwft_out_stage_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PW    = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              mrst_n,
    input logic              prst_n,
    input logic              ft,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rd_flag,
    input logic              wr_flag,
    input logic [DATA_W-1:0] rd_data,
    input logic [PW-1:0]     wptr,
    input logic [PW-1:0]     rptr
);
    logic [PW-1:0] occ;
    assign occ = wptr - rptr;

    assert_mode_kept_R1: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> $stable(ft));

    assert_std_prst_flags_R2: assert property (@(posedge clk) disable iff (!mrst_n)
        (!prst_n && !ft) |=> (!rd_flag && wr_flag));

    assert_ft_prst_flags_R3: assert property (@(posedge clk) disable iff (!mrst_n)
        (!prst_n && ft) |=> (rd_flag && !wr_flag));

    assert_std_hold_R5: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!ft && !(rd_en && rd_flag)) |=> $stable(rd_data));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        occ <= PW'(DEPTH));

    assert_wr_gate_R6: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (wr_en && (ft ? wr_flag : !wr_flag)) |=> $stable(wptr));

    assert_ft_hold_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (ft && !rd_flag && !rd_en) |=> (!rd_flag && $stable(rd_data)));
endmodule

bind fwft_out_stage fwft_out_stage_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .mrst_n  (mrst_n),
    .prst_n  (prst_n),
    .ft      (mode_q),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_flag (rd_flag),
    .wr_flag (wr_flag),
    .rd_data (rd_data),
    .wptr    (wptr),
    .rptr    (rptr)
);

// File: tb/sim_fwft_out_stage.sv
`timescale 1ns/1ps
module sim_fwft_out_stage;
    localparam int DW    = 16;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          mode_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_flag;
    logic          wr_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int n_acc = 0;
    bit ft_mode = 1'b0;
    bit done = 1'b0;
    logic [DW-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    fwft_out_stage #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_flag(rd_flag), .wr_flag(wr_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Driver: one cycle of stimulus; accepted writes go to the scoreboard.
    task automatic drive(input logic w, input logic [DW-1:0] d, input logic r);
        bit acc;
        acc = w && (ft_mode ? (wr_flag == 1'b0) : (wr_flag == 1'b1));
        wr_en = w; wr_data = d; rd_en = r;
        step();
        wr_en = 1'b0; rd_en = 1'b0;
        if (acc) begin
            exp_q.push_back(d);
            n_acc++;
        end
    endtask

    task automatic master_reset(input bit ft);
        mrst_n = 1'b0; mode_sel = ft;
        step(); step();
        mrst_n = 1'b1; mode_sel = ~ft;
        ft_mode = ft;
        exp_q.delete();
    endtask

    task automatic partial_reset();
        prst_n = 1'b0;
        step();
        prst_n = 1'b1;
        exp_q.delete();
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 40; k++) begin
            if (ft_mode ? (rd_flag == 1'b1) : (rd_flag == 1'b0)) break;
            drive(1'b0, '0, 1'b1);
        end
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // Monitor: compare every consumed word with the scoreboard head.
    logic          m_ren, m_flag, m_live;
    logic [DW-1:0] m_prev, m_exp;
    always @(posedge clk) begin
        m_ren = rd_en; m_flag = rd_flag; m_prev = rd_data;
        m_live = mrst_n && prst_n;
        #1;
        if (m_live && m_ren) begin
            if (!ft_mode && m_flag) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 read with empty scoreboard", rd_data, 0);
                else begin
                    m_exp = exp_q.pop_front();
                    chk(rd_data == m_exp, "R4 read data order", rd_data, m_exp);
                end
            end else if (ft_mode && !m_flag) begin
                if (exp_q.size() == 0) chk(1'b0, "R8 consume with empty scoreboard", m_prev, 0);
                else begin
                    m_exp = exp_q.pop_front();
                    chk(m_prev == m_exp, "R8 consumed word order", m_prev, m_exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        @(negedge clk);

        // ---------------- standard mode ----------------
        master_reset(1'b0);
        chk(rd_flag == 1'b0, "R2 empty flag after master reset", rd_flag, 0);
        chk(wr_flag == 1'b1, "R2 full flag after master reset", wr_flag, 1);

        drive(1'b1, 16'hA001, 1'b0);
        chk(rd_flag == 1'b1, "R4 not-empty after first write", rd_flag, 1);
        drive(1'b1, 16'hA002, 1'b0);
        drive(1'b1, 16'hA003, 1'b0);
        step(); step(); step();
        chk(rd_data == 16'h0000, "R1 standard mode shows nothing without read", rd_data, 0);
        for (int i = 0; i < 3; i++) drive(1'b0, '0, 1'b1);
        chk(rd_flag == 1'b0, "R4 empty after last read", rd_flag, 0);
        held = rd_data;
        drive(1'b0, '0, 1'b1);
        chk(rd_data == held, "R5 read while empty holds data", rd_data, held);
        chk(rd_data == 16'hA003, "R5 held value is last word", rd_data, 16'hA003);

        for (int i = 0; i < DEPTH; i++) drive(1'b1, DW'(16'hB000 + i), 1'b0);
        chk(wr_flag == 1'b0, "R6 full flag after DEPTH writes", wr_flag, 0);
        drive(1'b1, 16'hDEAD, 1'b0);
        chk(exp_q.size() == DEPTH, "R6 write while full not accepted", exp_q.size(), DEPTH);
        drain("R6 drain holds exactly DEPTH words");
        chk(rd_flag == 1'b0, "R6 empty after drain", rd_flag, 0);

        drive(1'b1, 16'hC001, 1'b0);
        drive(1'b1, 16'hC002, 1'b0);
        partial_reset();
        chk(rd_flag == 1'b0, "R2 empty flag after partial reset", rd_flag, 0);
        chk(wr_flag == 1'b1, "R2 full flag after partial reset", wr_flag, 1);

        // ---------------- fall-through mode ----------------
        master_reset(1'b1);
        chk(rd_flag == 1'b1, "R3 output-ready high after master reset", rd_flag, 1);
        chk(wr_flag == 1'b0, "R3 input-ready low after master reset", wr_flag, 0);

        drive(1'b1, 16'hD001, 1'b0);
        chk(rd_flag == 1'b1, "R7 not valid right after write edge", rd_flag, 1);
        rd_en = 1'b1;
        step();
        chk(rd_flag == 1'b1, "R7 not valid after first edge", rd_flag, 1);
        step();
        chk(rd_flag == 1'b1, "R7 not valid after second edge", rd_flag, 1);
        rd_en = 1'b0;
        step();
        chk(rd_flag == 1'b0, "R7 valid after third edge", rd_flag, 0);
        chk(rd_data == 16'hD001, "R7 R9 word shown and not consumed early", rd_data, 16'hD001);
        step();
        chk(rd_flag == 1'b0 && rd_data == 16'hD001, "R8 word holds without request", rd_data, 16'hD001);
        drive(1'b0, '0, 1'b1);
        chk(rd_flag == 1'b1, "R8 last word consumed sets flag high", rd_flag, 1);

        for (int i = 0; i < 5; i++) drive(1'b1, DW'(16'hE000 + i), 1'b0);
        step(); step(); step(); step();
        drain("R8 streamed burst fully consumed");
        chk(rd_flag == 1'b1, "R8 flag high after burst", rd_flag, 1);

        for (int i = 0; i < 24; i++) drive(i < 16, DW'(16'hF000 + i), i >= 2);
        drain("R8 concurrent read and write ordering");

        n_acc = 0;
        for (int i = 0; i < 20; i++) drive(1'b1, DW'(16'h1000 + i), 1'b0);
        chk(n_acc == DEPTH + 1, "R10 capacity is DEPTH plus one", n_acc, DEPTH + 1);
        chk(wr_flag == 1'b1, "R10 input-ready high when full", wr_flag, 1);
        step(); step(); step(); step();
        drive(1'b0, '0, 1'b1);
        chk(wr_flag == 1'b1, "R10 still full after consuming edge", wr_flag, 1);
        step();
        chk(wr_flag == 1'b1, "R10 still full after next edge", wr_flag, 1);
        step();
        chk(wr_flag == 1'b0, "R10 ready after second edge", wr_flag, 0);
        drain("R6 rejected writes absent from drained data");

        drive(1'b1, 16'h2001, 1'b0);
        drive(1'b1, 16'h2002, 1'b0);
        mode_sel = 1'b0;
        partial_reset();
        chk(rd_flag == 1'b1, "R3 output-ready high after partial reset", rd_flag, 1);
        chk(wr_flag == 1'b0, "R3 input-ready low after partial reset", wr_flag, 0);
        drive(1'b1, 16'h3001, 1'b0);
        step(); step();
        chk(rd_flag == 1'b1, "R1 mode kept: not valid after second edge", rd_flag, 1);
        step();
        chk(rd_flag == 1'b0 && rd_data == 16'h3001, "R1 mode kept through partial reset",
            rd_data, 16'h3001);
        drain("R8 final drain");

        finish_run();
    end
endmodule